// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Divider

This block divides its clock by a programmable ratio using the pulse-swallow technique. A small modulus counter runs as a prescaler that can divide by either a base value P or by P+1. Two cooperating counters steer it. A swallow counter holds the number of prescaler cycles that must run at P+1. A main counter holds the total number of prescaler cycles in one output period. The overall ratio is therefore N = B·P + A, set by three inputs, without one wide modulo counter.

All logic runs in the single input clock domain. Configuration inputs are sampled into a shadow copy on every cycle. The running copy is refreshed only when a period ends, so a new setting never cuts a period short. A configuration that cannot produce the stated ratio is reported on a flag, and the output stays quiet until a usable setting arrives.

Top module: `pswallow_div`

## Requirements
- R1: The cycles from one rising edge of `pulse_o` to the next equal B·P+A. In each period the first A prescaler cycles last P+1 clocks and the remaining B−A last P clocks.
- R2: `mod_sel` selects P as follows: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64 (P+1 is 9, 17, 33 or 65).
- R3: `swallow_a` is a 6-bit unsigned value and `main_b` is a 12-bit unsigned value. A = 0 makes every prescaler cycle last P clocks, so the ratio is exactly B·P. A = B is also legal.
- R4: `pulse_o` is high for exactly one clock per period, in the cycle that follows the edge at which both counters reload.
- R5: Input values changed during a period do not alter that period's length. They take effect from the following period on.
- R6: If the running setting has A > B or B < 3, `invalid_o` goes high one clock after that setting is loaded. `pulse_o` stays low for as long as `invalid_o` is high.
- R7: While the running setting is invalid, the block reloads from the inputs every clock. Once a valid setting is presented, periods of its ratio follow.
- R8: While `rst` is high, `pulse_o` and `invalid_o` are low and the inputs present during reset are loaded. The first pulse follows N clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| mod_sel | input | 2 | Prescaler base select (P = 8, 16, 32, 64) |
| swallow_a | input | 6 | Number of P+1 prescaler cycles per period |
| main_b | input | 12 | Total prescaler cycles per period |
| pulse_o | output | 1 | One-clock pulse, once every B·P+A clocks |
| invalid_o | output | 1 | High while the running setting breaks A ≤ B or B ≥ 3 |

## Verification
The bench measures every output period in all four prescaler modes. It covers A = 0, A = B, the smallest legal B and the widest prescaler. A design that counted the swallow cycles at the wrong place, or decoded the select incorrectly, would produce periods off by A or by a multiple of B. The bench changes settings mid-period: a design without the shadow copy would produce one period that is neither the old ratio nor the new one. It also drives both illegal forms and checks the recovery from them. A broken check would either keep pulsing on a bad setting or stay stuck once a good setting returns.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  localparam int unsigned P_LOG_BASE = 3;

  typedef enum logic [1:0] {
    MOD_8  = 2'b00,
    MOD_16 = 2'b01,
    MOD_32 = 2'b10,
    MOD_64 = 2'b11
  } mod_sel_e;

  // base modulus P for a select code
  function automatic int unsigned base_mod(input logic [1:0] sel);
    return 32'd1 << (P_LOG_BASE + int'(sel));
  endfunction

endpackage

// File: rtl/pswallow_cfg.sv
module pswallow_cfg #(
  parameter int A_W  = 6,
  parameter int B_W  = 12,
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reload,
  input  logic [PS_W-1:0] in_sel,
  input  logic [A_W-1:0]  in_a,
  input  logic [B_W-1:0]  in_b,
  output logic [PS_W-1:0] act_sel,
  output logic [A_W-1:0]  act_a,
  output logic [B_W-1:0]  act_b,
  output logic [A_W-1:0]  ld_a,
  output logic [B_W-1:0]  ld_b,
  output logic            act_ok
);

  logic [PS_W-1:0] sh_sel;
  logic [A_W-1:0]  sh_a;
  logic [B_W-1:0]  sh_b;

  always_ff @(posedge clk) begin
    sh_sel <= in_sel;
    sh_a   <= in_a;
    sh_b   <= in_b;
  end

  always_comb begin
    ld_a = rst ? in_a : sh_a;
    ld_b = rst ? in_b : sh_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= in_sel;
      act_a   <= in_a;
      act_b   <= in_b;
    end else if (reload) begin
      act_sel <= sh_sel;
      act_a   <= sh_a;
      act_b   <= sh_b;
    end
  end

  assign act_ok = (act_b >= B_W'(act_a)) && (act_b >= B_W'(3));

endmodule

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
#(
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [PS_W-1:0] sel,
  input  logic            extra,
  output logic            tick
);

  localparam int MAX_MOD = (1 << (P_LOG_BASE + (1 << PS_W) - 1)) + 1;
  localparam int PC_W    = $clog2(MAX_MOD);

  logic [PC_W-1:0] pcnt;
  logic [PC_W-1:0] last_val;

  always_comb begin
    last_val = PC_W'(base_mod(sel)) - PC_W'(1);
    if (extra) last_val = last_val + PC_W'(1);
  end

  assign tick = (pcnt == last_val);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) pcnt <= '0;
    else                        pcnt <= pcnt + PC_W'(1);
  end

endmodule

// File: rtl/pswallow_counters.sv
module pswallow_counters #(
  parameter int A_W = 6,
  parameter int B_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           hold,
  input  logic           tick,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           extra,
  output logic           last
);

  logic [A_W-1:0] acnt;
  logic [B_W-1:0] bcnt;

  assign extra = (acnt != '0);
  assign last  = (bcnt == B_W'(1));

  always_ff @(posedge clk) begin
    if (rst || hold || (tick && last)) begin
      acnt <= ld_a;
      bcnt <= ld_b;
    end else if (tick) begin
      bcnt <= bcnt - B_W'(1);
      if (extra) acnt <= acnt - A_W'(1);
    end
  end

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div #(
  parameter int A_W  = 6,
  parameter int B_W  = 12,
  parameter int PS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PS_W-1:0] mod_sel,
  input  logic [A_W-1:0]  swallow_a,
  input  logic [B_W-1:0]  main_b,
  output logic            pulse_o,
  output logic            invalid_o
);

  logic [PS_W-1:0] act_sel;
  logic [A_W-1:0]  act_a, ld_a;
  logic [B_W-1:0]  act_b, ld_b;
  logic            act_ok, ps_tick, sw_extra, sw_last, hold, boundary;

  assign hold     = !act_ok;
  assign boundary = ps_tick && sw_last && act_ok;

  pswallow_cfg #(.A_W(A_W), .B_W(B_W), .PS_W(PS_W)) u_cfg (
    .clk(clk), .rst(rst), .reload(boundary || hold),
    .in_sel(mod_sel), .in_a(swallow_a), .in_b(main_b),
    .act_sel(act_sel), .act_a(act_a), .act_b(act_b),
    .ld_a(ld_a), .ld_b(ld_b), .act_ok(act_ok)
  );

  pswallow_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst(rst), .restart(hold), .sel(act_sel),
    .extra(sw_extra), .tick(ps_tick)
  );

  pswallow_counters #(.A_W(A_W), .B_W(B_W)) u_cnt (
    .clk(clk), .rst(rst), .hold(hold), .tick(ps_tick),
    .ld_a(ld_a), .ld_b(ld_b), .extra(sw_extra), .last(sw_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_o   <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      pulse_o   <= boundary;
      invalid_o <= hold;
    end
  end

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk
  import pswallow_pkg::*;
#(
  parameter int A_W  = 6,
  parameter int B_W  = 12,
  parameter int PS_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            pulse_o,
  input logic            invalid_o,
  input logic [PS_W-1:0] act_sel,
  input logic [A_W-1:0]  act_a,
  input logic [B_W-1:0]  act_b
);

  int unsigned gap, n_lat;
  logic        seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap   <= 0;
      n_lat <= 0;
      seen  <= 1'b0;
    end else begin
      gap <= pulse_o ? 1 : gap + 1;
      if (pulse_o) n_lat <= int'(act_b) * base_mod(act_sel) + int'(act_a);
      if (invalid_o)    seen <= 1'b0;
      else if (pulse_o) seen <= 1'b1;
    end
  end

  // R1: spacing of consecutive pulses equals the ratio loaded at the earlier one
  a_r1_period: assert property (@(posedge clk) disable iff (rst)
    (pulse_o && seen) |-> (gap == n_lat));

  // R4: pulse lasts a single clock
  a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);

  // R6: no pulse while the setting is flagged
  a_r6_quiet: assert property (@(posedge clk) disable iff (rst)
    invalid_o |-> !pulse_o);

  // R5: the running setting moves only on a boundary or while invalid
  a_r5_boundary_only: assert property (@(posedge clk) disable iff (rst)
    !($stable(act_a) && $stable(act_b) && $stable(act_sel)) |-> (pulse_o || invalid_o));

endmodule

bind pswallow_div pswallow_div_chk #(.A_W(A_W), .B_W(B_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst(rst), .pulse_o(pulse_o), .invalid_o(invalid_o),
  .act_sel(act_sel), .act_a(act_a), .act_b(act_b)
);

// File: tb/sim_pswallow_div.sv
`timescale 1ns/1ps
module sim_pswallow_div;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mod_sel = 2'b00;
  logic [5:0]  swallow_a = 6'd0;
  logic [11:0] main_b = 12'd3;
  logic        pulse_o, invalid_o;

  int unsigned n_cmp = 0, n_bad = 0;
  int          exp_q[$];
  string       cur_tag = "R8";
  bit          resync = 1'b0;
  int          cnt = 0;
  int          prev_n = 0;

  always #5 clk = ~clk;

  pswallow_div u0 (
    .clk(clk), .rst(rst), .mod_sel(mod_sel), .swallow_a(swallow_a),
    .main_b(main_b), .pulse_o(pulse_o), .invalid_o(invalid_o)
  );

  task automatic check(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int ratio(input logic [1:0] s, input int a, input int b);
    return b * (8 << s) + a;
  endfunction

  // monitor: measure pulse spacing, compare with queue head
  always @(negedge clk) begin
    if (rst) begin
      cnt = 0;
      check("R8 reset pulse", int'(pulse_o), 0);
      check("R8 reset invalid", int'(invalid_o), 0);
    end else if (pulse_o) begin
      if (resync) resync = 1'b0;
      else if (exp_q.size() == 0) check({cur_tag, " unexpected pulse"}, 1, 0);
      else check({cur_tag, " period"}, cnt, exp_q.pop_front());
      cnt = 1;
    end else begin
      cnt++;
    end
  end

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  // change inputs mid-period; in-progress period keeps old ratio
  task automatic apply(input string tag, input logic [1:0] s, input int a,
                       input int b, input int reps);
    @(posedge clk); #1;
    mod_sel = s; swallow_a = 6'(a); main_b = 12'(b);
    cur_tag = tag;
    exp_q.push_back(prev_n);
    prev_n = ratio(s, a, b);
    for (int i = 0; i < reps; i++) exp_q.push_back(prev_n);
    wait_drain();
  endtask

  initial begin
    // R8 + R2 + R3: reset with P=8, A=0, B=3 (smallest legal B)
    mod_sel = 2'b00; swallow_a = 6'd0; main_b = 12'd3;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    cur_tag = "R8";
    prev_n = ratio(2'b00, 0, 3);
    for (int i = 0; i < 3; i++) exp_q.push_back(prev_n);
    wait_drain();
    // R2 R1: P=16, A=5, B=7
    apply("R2", 2'b01, 5, 7, 3);
    // R3 R1: P=32, A=B=31
    apply("R3", 2'b10, 31, 31, 2);
    // R1: P=64, A=63, B=64 (widest prescaler, max A)
    apply("R1", 2'b11, 63, 64, 2);
    // R3: P=64 with A=0
    apply("R3", 2'b11, 0, 5, 2);
    // R5: change back to a short setting mid-period
    apply("R5", 2'b00, 7, 9, 3);
    // R6: A greater than B
    @(posedge clk); #1;
    mod_sel = 2'b01; swallow_a = 6'd9; main_b = 12'd4;
    cur_tag = "R6";
    exp_q.push_back(prev_n);
    wait_drain();
    repeat (3) @(negedge clk);
    check("R6 flag A>B", int'(invalid_o), 1);
    repeat (300) @(negedge clk);
    check("R6 flag held", int'(invalid_o), 1);
    // R6: B below 3 while already invalid
    @(posedge clk); #1;
    swallow_a = 6'd0; main_b = 12'd2;
    repeat (200) @(negedge clk);
    check("R6 flag B<3", int'(invalid_o), 1);
    // R7: recovery with a valid setting
    resync = 1'b1;
    @(posedge clk); #1;
    mod_sel = 2'b01; swallow_a = 6'd2; main_b = 12'd4;
    cur_tag = "R7";
    prev_n = ratio(2'b01, 2, 4);
    for (int i = 0; i < 3; i++) exp_q.push_back(prev_n);
    repeat (4) @(negedge clk);
    check("R7 flag cleared", int'(invalid_o), 0);
    wait_drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule